// File: doc/BRIEF.md
# UART Receive Event Interrupt Controller

This block sits next to a simple UART receiver and transmitter. It turns the receiver's character-level strobes into latched event flags, and each flag can be masked into a single interrupt request. The receiver reports each character at the midpoint of its last stop bit. It also flags whether that character was all zeros, whether a buffer was free to take it, and whether the character closes the current buffer. Separately, it strobes each idle (mark) bit it samples. The transmitter strobes when the final character of a buffer has been handed to its FIFO.

Software sees two 8-bit registers through a small write/read port: an event register and a mask register. Event bits are cleared by writing ones. Hardware sets an event bit whenever its condition occurs, and a set wins over a clear that lands in the same cycle. A long break raises the break event only once. A break-end event follows once a mark bit is seen. All-zero characters count as break characters: they never fill buffers and never count as dropped data.

Top module: `uevt_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the event register, the mask register, `reg_rdata` and `irq` are all zero.
- R2: The registers use vector bits [7:0]. Bits 7, 5 and 3 are reserved and always read as zero in both registers, whatever is written to them.
- R3: A write with `reg_wr_sel`=0 clears every event bit whose `reg_wdata` bit is 1. Event bits whose write bit is 0 keep their value.
- R4: A write with `reg_wr_sel`=1 loads the mask register from `reg_wdata` (reserved bits forced to zero).
- R5: `irq` is 1 exactly when some event bit and its mask bit are both 1. It changes on the same clock edge as the event and mask registers, and falls only once every unmasked set bit is cleared.
- R6: A character strobe with `rx_char_zero`=1 sets the break event (bit 4) and enters the break state. While in that state, further all-zero characters do not set bit 4 again.
- R7: An `rx_idle_bit` strobe while in the break state sets the break-end event (bit 6) and leaves the break state. An idle bit outside the break state sets nothing.
- R8: A non-zero character strobe with `rx_buf_avail`=0 sets the busy event (bit 2) and does not set bit 0.
- R9: A non-zero character strobe with `rx_buf_avail`=1 and `rx_buf_last`=1 sets the receive-buffer event (bit 0). With `rx_buf_last`=0 it sets nothing.
- R10: A `tx_last_load` strobe sets the transmit-buffer event (bit 1).
- R11: When a hardware set and a write-one clear hit the same event bit in the same cycle, the bit ends up set.
- R12: `reg_rdata` shows, one clock after the edge where `reg_rd_sel` is sampled, the mask register if `reg_rd_sel`=1 and otherwise the event register, as both stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_stop_mid | input | 1 | Character complete, at the midpoint of its last stop bit |
| rx_char_zero | input | 1 | Qualifies `rx_stop_mid`: the character was all zeros |
| rx_idle_bit | input | 1 | An idle (mark) bit was sampled |
| rx_buf_avail | input | 1 | A receive buffer is free |
| rx_buf_last | input | 1 | Qualifies `rx_stop_mid`: the character closes the buffer |
| tx_last_load | input | 1 | Last character of a transmit buffer entered the FIFO |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 event (write-one clear), 1 mask |
| reg_wdata | input | 8 | Write data |
| reg_rd_sel | input | 1 | Read select: 0 event, 1 mask |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check that reserved bits read as zero and that the interrupt agrees with the stored event and mask bits. They also check that every hardware set lands even under a concurrent clear, that written-one bits clear unless a set collides with them, that the break event fires only outside the break state, and that busy fires only for a non-zero character without a buffer. Only the bench's scenarios can show the sequence-level behaviour. Those behaviours are: one break event per long break, break end only after a break, no receive event for a non-closing character, and the one-cycle read latency with its select.

// File: rtl/uevt_pkg.sv
package uevt_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_BRKE = 6;
  localparam int BIT_BRK  = 4;
  localparam int BIT_BSY  = 2;
  localparam int BIT_TXB  = 1;
  localparam int BIT_RXB  = 0;

  typedef logic [REG_W-1:0] reg_t;

  localparam reg_t LIVE_MASK = reg_t'((1 << BIT_BRKE) | (1 << BIT_BRK) |
                                      (1 << BIT_BSY) | (1 << BIT_TXB) |
                                      (1 << BIT_RXB));
endpackage

// File: rtl/uevt_break_trk.sv
module uevt_break_trk (
  input  logic clk,
  input  logic rst,
  input  logic stop_mid,
  input  logic char_zero,
  input  logic idle_bit,
  output logic brk_start,
  output logic brk_end
);
  logic brk_q;

  always_comb begin
    brk_start = stop_mid & char_zero & ~brk_q;
    brk_end   = idle_bit & brk_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_q <= 1'b0;
    end else if (brk_start) begin
      brk_q <= 1'b1;
    end else if (brk_end) begin
      brk_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uevt_rx_class.sv
module uevt_rx_class (
  input  logic stop_mid,
  input  logic char_zero,
  input  logic buf_avail,
  input  logic buf_last,
  output logic busy,
  output logic rx_done
);
  logic data_char;

  always_comb begin
    data_char = stop_mid & ~char_zero;
    busy      = data_char & ~buf_avail;
    rx_done   = data_char & buf_avail & buf_last;
  end
endmodule

// File: rtl/uevt_regs.sv
module uevt_regs
  import uevt_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] LIVE = LIVE_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         wr,
  input  logic         wr_sel,
  input  logic [W-1:0] wdata,
  input  logic         rd_sel,
  output logic [W-1:0] ev_q,
  output logic [W-1:0] mk_q,
  output logic [W-1:0] rdata,
  output logic         irq
);
  logic [W-1:0] ev_d;
  logic [W-1:0] mk_d;
  logic         clr_en;

  assign clr_en = wr & ~wr_sel;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      always_comb ev_d[i] = set_vec[i] | (ev_q[i] & ~(clr_en & wdata[i]));
      always_ff @(posedge clk) begin
        if (rst) ev_q[i] <= 1'b0;
        else     ev_q[i] <= ev_d[i];
      end
    end else begin : g_rsvd
      always_comb ev_d[i] = 1'b0;
      always_comb ev_q[i] = 1'b0;
    end
  end

  always_comb mk_d = (wr & wr_sel) ? (wdata & LIVE) : mk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mk_q  <= '0;
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      mk_q  <= mk_d;
      rdata <= rd_sel ? mk_q : ev_q;
      irq   <= |(ev_d & mk_d);
    end
  end
endmodule

// File: rtl/uevt_irq_ctrl.sv
module uevt_irq_ctrl
  import uevt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_stop_mid,
  input  logic             rx_char_zero,
  input  logic             rx_idle_bit,
  input  logic             rx_buf_avail,
  input  logic             rx_buf_last,
  input  logic             tx_last_load,
  input  logic             reg_wr,
  input  logic             reg_wr_sel,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_rd_sel,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);
  logic brk_start, brk_end, busy, rx_done;
  reg_t set_vec, ev_q, mk_q;

  uevt_break_trk u_brk (
    .clk(clk), .rst(rst), .stop_mid(rx_stop_mid), .char_zero(rx_char_zero),
    .idle_bit(rx_idle_bit), .brk_start(brk_start), .brk_end(brk_end)
  );

  uevt_rx_class u_cls (
    .stop_mid(rx_stop_mid), .char_zero(rx_char_zero), .buf_avail(rx_buf_avail),
    .buf_last(rx_buf_last), .busy(busy), .rx_done(rx_done)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_BRK]  = brk_start;
    set_vec[BIT_BRKE] = brk_end;
    set_vec[BIT_BSY]  = busy;
    set_vec[BIT_RXB]  = rx_done;
    set_vec[BIT_TXB]  = tx_last_load;
  end

  uevt_regs #(.W(REG_W), .LIVE(LIVE_MASK)) u_regs (
    .clk(clk), .rst(rst), .set_vec(set_vec), .wr(reg_wr), .wr_sel(reg_wr_sel),
    .wdata(reg_wdata), .rd_sel(reg_rd_sel), .ev_q(ev_q), .mk_q(mk_q),
    .rdata(reg_rdata), .irq(irq)
  );
endmodule

// File: rtl/uevt_irq_ctrl_chk.sv
module uevt_irq_ctrl_chk
  import uevt_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic stop_mid,
  input logic char_zero,
  input logic buf_avail,
  input logic wr,
  input logic wr_sel,
  input reg_t wdata,
  input reg_t rdata,
  input logic irq,
  input reg_t set_vec,
  input reg_t ev_q,
  input reg_t mk_q,
  input logic in_break,
  input logic brk_start
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~LIVE_MASK) == '0);

  assert_irq_match_R5: assert property (@(posedge clk) disable iff (rst)
    irq == |(ev_q & mk_q));

  assert_set_lands_R11: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((ev_q & $past(set_vec)) == $past(set_vec)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && !wr_sel) |=> ((ev_q & $past(wdata) & ~$past(set_vec)) == '0));

  assert_brk_once_R6: assert property (@(posedge clk) disable iff (rst)
    brk_start |-> !in_break);

  assert_brk_enter_R6: assert property (@(posedge clk) disable iff (rst)
    brk_start |=> in_break);

  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (rst)
    set_vec[BIT_BSY] |-> (stop_mid && !char_zero && !buf_avail));
endmodule

bind uevt_irq_ctrl uevt_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .stop_mid(rx_stop_mid), .char_zero(rx_char_zero),
  .buf_avail(rx_buf_avail), .wr(reg_wr), .wr_sel(reg_wr_sel), .wdata(reg_wdata),
  .rdata(reg_rdata), .irq(irq), .set_vec(set_vec), .ev_q(ev_q), .mk_q(mk_q),
  .in_break(u_brk.brk_q), .brk_start(brk_start)
);

// File: tb/tb_uevt_irq_ctrl.sv
module tb_uevt_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LIVE = 8'h57;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_stop_mid = 0, rx_char_zero = 0, rx_idle_bit = 0, rx_buf_avail = 0;
  logic rx_buf_last = 0, tx_last_load = 0, reg_wr = 0, reg_wr_sel = 0, reg_rd_sel = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_ev = '0, m_mk = '0, m_rd = '0;
  logic m_brk = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uevt_irq_ctrl dut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] setv(logic sm, logic z, logic idl, logic av,
                                      logic lst, logic tl, logic brk);
    logic [7:0] s = '0;
    s[4] = sm & z & ~brk;
    s[6] = idl & brk;
    s[2] = sm & ~z & ~av;
    s[0] = sm & ~z & av & lst;
    s[1] = tl;
    return s;
  endfunction

  task automatic step(string tag, logic sm, logic z, logic idl, logic av, logic lst,
                      logic tl, logic wr, logic ws, logic [7:0] wd, logic rs);
    logic [7:0] s;
    @(negedge clk);
    rx_stop_mid = sm; rx_char_zero = z; rx_idle_bit = idl; rx_buf_avail = av;
    rx_buf_last = lst; tx_last_load = tl; reg_wr = wr; reg_wr_sel = ws;
    reg_wdata = wd; reg_rd_sel = rs;
    s = setv(sm, z, idl, av, lst, tl, m_brk);
    m_rd = rs ? m_mk : m_ev;
    if (s[4]) m_brk = 1'b1;
    else if (s[6]) m_brk = 1'b0;
    m_ev = ((m_ev & ~((wr && !ws) ? wd : 8'h00)) | s) & LIVE;
    if (wr && ws) m_mk = wd & LIVE;
    m_irq = |(m_ev & m_mk);
    @(posedge clk); #1;
    check({tag, " rdata"}, reg_rdata, m_rd);
    check({tag, " irq"}, {7'd0, irq}, {7'd0, m_irq});
    rx_stop_mid = 0; rx_char_zero = 0; rx_idle_bit = 0; tx_last_load = 0; reg_wr = 0;
  endtask

  // read event (sel 0) or mask (sel 1) with no other activity
  task automatic rd(string tag, logic sel);
    step(tag, 0, 0, 0, 1, 0, 0, 0, 0, 8'h00, sel);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rd("R1", 1);
    // R4 and R2: mask loads, reserved bits read zero
    step("R4", 0, 0, 0, 1, 0, 0, 1, 1, 8'hFF, 0);
    rd("R2", 1);
    rd("R4", 1);
    // R6: first zero char sets break; later zero chars do not
    step("R6", 1, 1, 0, 1, 0, 0, 0, 0, 8'h00, 0);
    rd("R6", 0);
    step("R3", 0, 0, 0, 1, 0, 0, 1, 0, 8'h10, 0);
    step("R6", 1, 1, 0, 0, 0, 0, 0, 0, 8'h00, 0);
    rd("R6", 0);
    // R7: break end once, then idle does nothing
    step("R7", 0, 0, 1, 1, 0, 0, 0, 0, 8'h00, 0);
    rd("R7", 0);
    step("R7", 0, 0, 1, 1, 0, 0, 1, 0, 8'h40, 0);
    rd("R7", 0);
    // R8 busy, R9 receive done / not last, R10 transmit done
    step("R8", 1, 0, 0, 0, 1, 0, 0, 0, 8'h00, 0);
    rd("R8", 0);
    step("R9", 1, 0, 0, 1, 0, 0, 1, 0, 8'hFF, 0);
    rd("R9", 0);
    step("R9", 1, 0, 0, 1, 1, 0, 0, 0, 8'h00, 0);
    rd("R9", 0);
    step("R10", 0, 0, 0, 1, 0, 1, 0, 0, 8'h00, 0);
    rd("R10", 0);
    // R3: write zero leaves bits; R5: irq falls after full clear
    step("R3", 0, 0, 0, 1, 0, 0, 1, 0, 8'h00, 0);
    step("R5", 0, 0, 0, 1, 0, 0, 1, 0, 8'h01, 0);
    step("R5", 0, 0, 0, 1, 0, 0, 1, 0, 8'h02, 0);
    // R11: set and clear in the same cycle
    step("R11", 0, 0, 0, 1, 0, 1, 1, 0, 8'h02, 0);
    rd("R11", 0);
    // R5: masked event keeps irq low
    step("R5", 0, 0, 0, 1, 0, 0, 1, 1, 8'h01, 0);
    step("R5", 0, 0, 0, 1, 0, 1, 0, 0, 8'h00, 1);
    // R12 plus all: constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic sm, z, idl, av, lst, tl, wr, ws, rs;
      logic [7:0] wd;
      sm  = ($urandom_range(0, 3) == 0);
      z   = ($urandom_range(0, 2) == 0);
      idl = ($urandom_range(0, 4) == 0);
      av  = ($urandom_range(0, 3) != 0);
      lst = $urandom_range(0, 1);
      tl  = ($urandom_range(0, 6) == 0);
      wr  = ($urandom_range(0, 3) == 0);
      ws  = ($urandom_range(0, 3) == 0);
      rs  = $urandom_range(0, 1);
      wd  = 8'($urandom);
      step("R12", sm, z, idl, av, lst, tl, wr, ws, wd, rs);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule